// File: doc/BRIEF.md
# USB Shared-Buffer IN Responder for Endpoints 1 and 2

This block decides how a USB device answers an IN token sent to endpoint 1 or endpoint 2. Both endpoints draw on one transmit buffer. A control bit names the endpoint that currently owns that buffer. For each token the block reports one of four responses: no response, a data packet, NAK or STALL. With a data packet it also reports the data PID and the byte count. The serial engine that forms and sends packets uses these outputs, so bit coding, CRC and the buffer memory stay outside this block.

Software sets the control state through a single write strobe, which loads every control field at once. The fields are:

- a transmit-ready bit;
- the buffer-owner select;
- an enable bit and a force-stall bit for each endpoint;
- the DATA0/DATA1 sequence bit;
- a byte count;
- a force-resume bit for remote wakeup.

Hardware never changes the sequence bit; only a software write does. The force-resume bit puts the K state on the lines only while the bus is otherwise idle. A resume that this block drives itself never raises the resume-detected flag.

Top module: `usb_in_responder`

## Requirements
- R1: After reset, every control field is zero, so the sequence bit, owner select, transmit-ready, both enables, both stalls, byte count and force-resume are all zero. `resp_valid`, `tx_done`, `resume_k` and `resume_det` are all low.
- R2: Every cycle with `tok_valid` high produces exactly one `resp_valid` pulse on the next clock. `resp_type` encodes the response as 0=NONE, 1=DATA, 2=NAK, 3=STALL. A token whose endpoint number is neither 1 nor 2 gets NONE.
- R3: A token to an endpoint whose enable bit is 0 gets NONE, even when that endpoint's stall bit is set.
- R4: A token to an enabled endpoint whose own stall bit is set gets STALL. The stall bit of the other endpoint has no effect on it.
- R5: A token to an enabled endpoint that is not stalled gets NAK when transmit-ready is 0 or `buf_full` is 1.
- R6: If all other conditions for data are met but the owner select does not name the addressed endpoint, the answer is NAK. The select value 0 means endpoint 1 and 1 means endpoint 2.
- R7: A DATA response carries `resp_pid` equal to the stored sequence bit, where 0 means DATA0 and 1 means DATA1. The bit keeps its value across data responses until software writes it.
- R8: `resp_len` equals the stored byte count. A written count above 8 is stored as 8, and a count of 0 gives a zero-length data packet.
- R9: `tx_done` pulses for one cycle, on the cycle after each DATA response. It stays low after NONE, NAK and STALL responses.
- R10: `resume_k` is high exactly when force-resume is set and `bus_idle` is high.
- R11: `resume_det` sets on the cycle after `rx_k` is seen while force-resume is 0. It does not set while force-resume is 1. A write with `cfg_clr_resdet` set clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Loads all control fields below |
| cfg_seq | input | 1 | Data PID sequence bit |
| cfg_sel | input | 1 | Buffer owner: 0 endpoint 1, 1 endpoint 2 |
| cfg_txen | input | 1 | Transmit data ready |
| cfg_ep1_en | input | 1 | Endpoint 1 enable |
| cfg_ep2_en | input | 1 | Endpoint 2 enable |
| cfg_ep1_stall | input | 1 | Endpoint 1 force stall |
| cfg_ep2_stall | input | 1 | Endpoint 2 force stall |
| cfg_len | input | 4 | Transmit byte count, saturated to 8 |
| cfg_resume | input | 1 | Force resume (remote wakeup) |
| cfg_clr_resdet | input | 1 | Clears the resume-detected flag |
| buf_full | input | 1 | Shared transmit buffer busy |
| tok_valid | input | 1 | IN token strobe |
| tok_ep | input | 4 | Endpoint number of the token |
| bus_idle | input | 1 | Bus is in the idle state |
| rx_k | input | 1 | Receiver sees K state |
| resp_valid | output | 1 | Response strobe |
| resp_type | output | 2 | 0 NONE, 1 DATA, 2 NAK, 3 STALL |
| resp_pid | output | 1 | 0 DATA0, 1 DATA1 |
| resp_len | output | 4 | Byte count of the data packet |
| tx_done | output | 1 | Data packet transmitted pulse |
| resume_k | output | 1 | Drive K on the lines |
| resume_det | output | 1 | Resume detected from the bus |

## Verification
The assertions assume that `tok_valid` is a clean strobe. They also assume that `buf_full` and the control fields are steady around the clock edge that samples a token. If a control write and a token arrive in the same cycle, the token is judged on the old settings. The stimulus changes every input on the falling edge. It never issues a write and a token in the same cycle, and it leaves `rx_k` low while a clear of the resume flag is written. This keeps every expected response tied to settings that are already stored.

// File: rtl/usb_in_responder.sv
module usb_in_responder #(
  parameter int LEN_W   = 4,
  parameter int MAX_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_seq,
  input  logic             cfg_sel,
  input  logic             cfg_txen,
  input  logic             cfg_ep1_en,
  input  logic             cfg_ep2_en,
  input  logic             cfg_ep1_stall,
  input  logic             cfg_ep2_stall,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_resume,
  input  logic             cfg_clr_resdet,
  input  logic             buf_full,
  input  logic             tok_valid,
  input  logic [3:0]       tok_ep,
  input  logic             bus_idle,
  input  logic             rx_k,
  output logic             resp_valid,
  output logic [1:0]       resp_type,
  output logic             resp_pid,
  output logic [LEN_W-1:0] resp_len,
  output logic             tx_done,
  output logic             resume_k,
  output logic             resume_det
);
  localparam logic [1:0] T_NONE  = 2'd0;
  localparam logic [1:0] T_DATA  = 2'd1;
  localparam logic [1:0] T_NAK   = 2'd2;
  localparam logic [1:0] T_STALL = 2'd3;
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);

  logic             seq_q, sel_q, txen_q, en1_q, en2_q, st1_q, st2_q, res_q;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {seq_q, sel_q, txen_q, en1_q, en2_q, st1_q, st2_q, res_q} <= '0;
      len_q <= '0;
    end else if (cfg_we) begin
      seq_q  <= cfg_seq;
      sel_q  <= cfg_sel;
      txen_q <= cfg_txen;
      en1_q  <= cfg_ep1_en;
      en2_q  <= cfg_ep2_en;
      st1_q  <= cfg_ep1_stall;
      st2_q  <= cfg_ep2_stall;
      res_q  <= cfg_resume;
      len_q  <= (cfg_len > LEN_CAP) ? LEN_CAP : cfg_len;
    end
  end

  wire is_ep1  = (tok_ep == 4'd1);
  wire is_ep2  = (tok_ep == 4'd2);
  wire ep_en   = (is_ep1 & en1_q) | (is_ep2 & en2_q);
  wire ep_st   = (is_ep1 & st1_q) | (is_ep2 & st2_q);
  wire owns    = is_ep2 ? sel_q : ~sel_q;
  wire can_tx  = txen_q & ~buf_full & owns;

  logic [1:0] decide;
  always_comb begin
    if (!ep_en)      decide = T_NONE;
    else if (ep_st)  decide = T_STALL;
    else if (!can_tx) decide = T_NAK;
    else             decide = T_DATA;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_type  <= T_NONE;
      resp_pid   <= 1'b0;
      resp_len   <= '0;
      tx_done    <= 1'b0;
    end else begin
      resp_valid <= tok_valid;
      if (tok_valid) begin
        resp_type <= decide;
        resp_pid  <= seq_q;
        resp_len  <= len_q;
      end
      tx_done <= resp_valid & (resp_type == T_DATA);
    end
  end

  assign resume_k = res_q & bus_idle;

  always_ff @(posedge clk) begin
    if (!rst_n)                       resume_det <= 1'b0;
    else if (cfg_we && cfg_clr_resdet) resume_det <= 1'b0;
    else if (rx_k && !res_q)          resume_det <= 1'b1;
  end

  // R2
  resp_after_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(tok_valid));
  // R5
  data_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && buf_full) |=> (resp_type != T_DATA));
  // R8
  len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_len <= LEN_CAP));
  // R9
  done_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> ($past(resp_valid) && $past(resp_type) == T_DATA));
  // R10
  resume_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_k |-> bus_idle);
  // R11
  resdet_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_det) |-> ($past(rx_k) && !$past(res_q)));
endmodule

// File: tb/usb_in_responder_bench.sv
module usb_in_responder_bench;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_seq = 0, cfg_sel = 0, cfg_txen = 0, cfg_ep1_en = 0, cfg_ep2_en = 0;
  logic cfg_ep1_stall = 0, cfg_ep2_stall = 0, cfg_resume = 0, cfg_clr_resdet = 0;
  logic [3:0] cfg_len = 0, tok_ep = 0;
  logic buf_full = 0, tok_valid = 0, bus_idle = 0, rx_k = 0;
  logic resp_valid, resp_pid, tx_done, resume_k, resume_det;
  logic [1:0] resp_type;
  logic [3:0] resp_len;
  int total = 0, bad = 0;

  usb_in_responder u_usb_in_responder (.*);

  always #10 clk = ~clk;

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(bit seq, bit sel, bit txen, bit e1, bit e2, bit s1, bit s2,
                    logic [3:0] len, bit res, bit clr);
    @(negedge clk);
    cfg_we = 1; cfg_seq = seq; cfg_sel = sel; cfg_txen = txen;
    cfg_ep1_en = e1; cfg_ep2_en = e2; cfg_ep1_stall = s1; cfg_ep2_stall = s2;
    cfg_len = len; cfg_resume = res; cfg_clr_resdet = clr;
    @(negedge clk);
    cfg_we = 0; cfg_clr_resdet = 0;
  endtask

  task automatic token(logic [3:0] ep, string req, int exp_type);
    @(negedge clk);
    tok_valid = 1; tok_ep = ep;
    @(negedge clk);
    tok_valid = 0;
    check({req, " resp_valid"}, resp_valid, 1);
    check({req, " resp_type"}, resp_type, exp_type);
  endtask

  task automatic t_reset;
    check("R1 resp_valid", resp_valid, 0);
    check("R1 tx_done", tx_done, 0);
    bus_idle = 1;
    #1 check("R1 resume_k", resume_k, 0);
    check("R1 resume_det", resume_det, 0);
    token(4'd1, "R1 ep1 disabled", 0);
    @(negedge clk);
    check("R2 single pulse", resp_valid, 0);
  endtask

  task automatic t_disabled;
    wr(0, 0, 1, 0, 0, 1, 1, 4, 0, 0);
    token(4'd1, "R3 ep1", 0);
    token(4'd2, "R3 ep2", 0);
    wr(0, 0, 1, 1, 1, 0, 0, 4, 0, 0);
    token(4'd0, "R2 ep0", 0);
    token(4'd5, "R2 ep5", 0);
  endtask

  task automatic t_stall;
    wr(0, 0, 1, 1, 1, 1, 0, 4, 0, 0);
    token(4'd1, "R4 ep1 stall", 3);
    token(4'd2, "R4 ep2 unaffected", 2);
    wr(0, 1, 1, 1, 1, 0, 1, 4, 0, 0);
    token(4'd2, "R4 ep2 stall", 3);
    token(4'd1, "R4 ep1 unaffected", 2);
  endtask

  task automatic t_nak;
    wr(0, 0, 0, 1, 1, 0, 0, 4, 0, 0);
    token(4'd1, "R5 txen0", 2);
    @(negedge clk);
    check("R9 no done after NAK", tx_done, 0);
    wr(0, 0, 1, 1, 1, 0, 0, 4, 0, 0);
    buf_full = 1;
    token(4'd1, "R5 busy", 2);
    buf_full = 0;
    token(4'd2, "R6 ep2 not owner", 2);
    wr(0, 1, 1, 1, 1, 0, 0, 4, 0, 0);
    token(4'd1, "R6 ep1 not owner", 2);
  endtask

  task automatic t_data;
    wr(1, 1, 1, 0, 1, 0, 0, 4'd5, 0, 0);
    token(4'd2, "R7 ep2 data", 1);
    check("R7 pid DATA1", resp_pid, 1);
    check("R8 len 5", resp_len, 5);
    @(negedge clk);
    check("R9 done pulse", tx_done, 1);
    @(negedge clk);
    check("R9 done one cycle", tx_done, 0);
    token(4'd2, "R7 second data", 1);
    check("R7 pid kept", resp_pid, 1);
    wr(0, 0, 1, 1, 0, 0, 0, 4'd0, 0, 0);
    token(4'd1, "R8 zero length", 1);
    check("R7 pid DATA0", resp_pid, 0);
    check("R8 len 0", resp_len, 0);
    wr(0, 0, 1, 1, 0, 0, 0, 4'd13, 0, 0);
    token(4'd1, "R8 saturate", 1);
    check("R8 len 8", resp_len, 8);
    wr(0, 0, 1, 1, 0, 0, 0, 4'd8, 0, 0);
    token(4'd1, "R8 max", 1);
    check("R8 len 8 exact", resp_len, 8);
  endtask

  task automatic t_resume;
    wr(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    bus_idle = 1;
    #1 check("R10 idle forced", resume_k, 1);
    @(negedge clk);
    bus_idle = 0;
    #1 check("R10 busy bus", resume_k, 0);
    rx_k = 1;
    @(negedge clk);
    rx_k = 0;
    check("R11 no set while forcing", resume_det, 0);
    wr(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    bus_idle = 1;
    #1 check("R10 not forced", resume_k, 0);
    @(negedge clk);
    rx_k = 1;
    @(negedge clk);
    rx_k = 0;
    check("R11 set by bus K", resume_det, 1);
    @(negedge clk);
    check("R11 sticky", resume_det, 1);
    wr(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    check("R11 cleared", resume_det, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_disabled;
    t_stall;
    t_nak;
    t_data;
    t_resume;
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule